// File: doc/BRIEF.md
# Protected Page Write Controller

This block sits behind a two-wire serial slave front end and owns a 256-byte storage array. The front end marks the beginning of a write with a start address, delivers data bytes one at a time and marks the end of the transaction. Bytes are collected in a 16-byte page buffer. Each byte lands at the next offset within the 16-byte page of the start address, and the offset wraps inside that page. If more than 16 bytes arrive, the newest byte overwrites the oldest one still held.

When a transaction ends with at least one buffered byte, the controller starts a self-timed write cycle. It raises `busy` so that the front end withholds acknowledges. When the cycle ends, it commits every buffered byte that may be written. Two protections decide whether a byte may be written:
- A one-time lock, set by a command and cleared only by reset, guards the lower half of the array.
- A protect pin, when high, guards the whole array.

Both are sampled when the cycle begins. A read port returns array contents, with or without a register stage, and is blocked while the write cycle runs.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `rd_valid` is 1, every array byte reads 00h and the lock is clear, so a write to the lower half is committed.
- R2: Byte k of a transaction, counting from 0, with start address S is written to address {S[7:4], (S[3:0]+k) mod 16}. The offset wraps from Fh to 0h and never carries into the page number.
- R3: When more than 16 bytes arrive in one transaction, only the last 16 are committed. Each new byte replaces the oldest byte held.
- R4: A transaction end that is accepted with at least one byte buffered raises `busy` at the next clock edge. `busy` then stays high for exactly WRITE_CYCLES cycles, and the array shows the new data once `busy` is low.
- R5: A transaction end with no data byte does not raise `busy` and leaves the array unchanged.
- R6: While the lock is set, writes to 00h–7Fh are discarded and writes to 80h–FFh are committed.
- R7: Once set, the lock stays set through any later command or transaction and is cleared only by reset.
- R8: If `wp_pin` is 1 at the clock edge that accepts the transaction end, no byte of that transaction is written, whatever the lock holds. Changes of `wp_pin` during the write cycle have no effect on it.
- R9: While `busy` is 1, `txn_start`, `byte_valid`, `txn_end` and `lock_cmd` are ignored.
- R10: With RD_REG=0, `rd_data` shows the array byte at `rd_addr` in the same cycle. With RD_REG=1 it shows it one clock later. While `busy` is 1 (RD_REG=0), or was 1 in the previous cycle (RD_REG=1), `rd_valid` is 0 and `rd_data` is 00h.
- R11: A byte presented in the same cycle as the transaction end is included in the commit. A lock command in that cycle does not protect that commit, but it does protect every later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the lock and the array |
| txn_start | input | 1 | Begin a write transaction at `txn_addr` |
| txn_addr | input | ADDR_W | Start address of the transaction |
| byte_valid | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | DATA_W | Data byte |
| txn_end | input | 1 | End of the transaction; commit if bytes are held |
| lock_cmd | input | 1 | Set the lower-half lock |
| wp_pin | input | 1 | Whole-array write protect |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, 0 when blocked |
| rd_valid | output | 1 | Read data is valid |

## Verification
The cycle that accepts the transaction end can also carry the final data byte and a lock command. The commit must take the byte but evaluate protection with the lock value from before that edge. The bench drives all three in one cycle on a lower-half page. It expects every byte to be committed, and it expects a write to the same half in the next transaction to be discarded. A second collision is stimulus arriving during the write cycle. Start, byte, end and lock are all pulsed mid-cycle, and the protect pin is flipped at the same time. The bench then confirms through reads that none of this changed the commit or the lock.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Decide whether a byte may be committed, given the sampled protect
  // pin, the sampled lock and whether the target lies in the upper half.
  function automatic logic write_allowed(input logic wp, input logic locked,
                                         input logic upper_half);
    return !wp && (!locked || upper_half);
  endfunction

  // Any pending work in the page: held bytes or one arriving now.
  function automatic logic page_has_data(input logic held, input logic arriving);
    return held || arriving;
  endfunction

endpackage

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [OFF_W-1:0]                     load_off,
  input  logic                                 clear,
  input  logic                                 wr_en,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    slot_data,
  output logic [PAGE_BYTES-1:0]                slot_vld,
  output logic                                 any_next
);
  import pgwr_pkg::*;

  logic [OFF_W-1:0] ptr;

  // A byte arriving now counts toward the commit decision.
  assign any_next = page_has_data(|slot_vld, wr_en);

  // Each slot is one page offset; a later byte at the same offset
  // replaces the older one, which keeps only the newest 16 bytes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      slot_vld  <= '0;
      slot_data <= '0;
    end else if (load) begin
      ptr      <= load_off;
      slot_vld <= '0;
    end else if (clear) begin
      slot_vld <= '0;
    end else if (wr_en) begin
      slot_data[ptr] <= wr_data;
      slot_vld[ptr]  <= 1'b1;
      ptr            <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pgwr_commit_seq.sv
module pgwr_commit_seq #(
  parameter int WRITE_CYCLES = 500000,
  parameter int CW           = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic wp_in,
  input  logic lock_in,
  output logic busy,
  output logic done,
  output logic wp_snap,
  output logic lock_snap
);
  logic [CW-1:0] remain;

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      wp_snap   <= 1'b0;
      lock_snap <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        busy      <= 1'b1;
        remain    <= CW'(WRITE_CYCLES - 1);
        wp_snap   <= wp_in;
        lock_snap <= lock_in;
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/pgwr_lock_latch.sv
module pgwr_lock_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic locked
);
  // Set-only: no input path returns it to zero; reset alone does.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500000,
  parameter int RD_REG       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              txn_end,
  input  logic              lock_cmd,
  input  logic              wp_pin,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import pgwr_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  // Named internal events, also observed by the checker.
  logic start_ok, end_ok, byte_ok, commit_go, commit_done;
  logic buf_any_next, lock_q, wp_snap, lock_snap, page_msb, allow_wr, arr_we;
  logic in_txn;
  logic [PG_W-1:0] page_q;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
  logic [PAGE_BYTES-1:0]             slot_vld;
  logic [DATA_W-1:0] mem [DEPTH];

  assign start_ok  = txn_start && !busy;
  assign byte_ok   = byte_valid && in_txn && !busy && !txn_start;
  assign end_ok    = txn_end && in_txn && !busy && !txn_start;
  assign commit_go = end_ok && buf_any_next;
  assign page_msb  = page_q[PG_W-1];
  assign allow_wr  = write_allowed(wp_snap, lock_snap, page_msb);
  assign arr_we    = commit_done && allow_wr && (|slot_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_txn <= 1'b0;
      page_q <= '0;
    end else if (start_ok) begin
      in_txn <= 1'b1;
      page_q <= txn_addr[ADDR_W-1:OFF_W];
    end else if (end_ok) begin
      in_txn <= 1'b0;
    end
  end

  pgwr_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(start_ok), .load_off(txn_addr[OFF_W-1:0]),
    .clear(commit_done), .wr_en(byte_ok), .wr_data(byte_data),
    .slot_data(slot_data), .slot_vld(slot_vld), .any_next(buf_any_next)
  );

  pgwr_lock_latch u_lock (
    .clk(clk), .rst_n(rst_n), .set_req(lock_cmd && !busy), .locked(lock_q)
  );

  pgwr_commit_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(commit_go),
    .wp_in(wp_pin), .lock_in(lock_q),
    .busy(busy), .done(commit_done),
    .wp_snap(wp_snap), .lock_snap(lock_snap)
  );

  // Storage array: the whole page is committed on the last busy edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (arr_we) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (slot_vld[i]) mem[{page_q, OFF_W'(i)}] <= slot_data[i];
    end
  end

  generate
    if (RD_REG == 0) begin : g_rd_comb
      assign rd_data  = busy ? '0 : mem[rd_addr];
      assign rd_valid = !busy;
    end else begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_data  <= '0;
          rd_valid <= 1'b0;
        end else begin
          rd_data  <= busy ? '0 : mem[rd_addr];
          rd_valid <= !busy;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int WRITE_CYCLES = 500000,
  parameter int RD_REG       = 0
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rd_valid,
  input logic lock_q,
  input logic buf_any_next,
  input logic end_ok,
  input logic arr_we,
  input logic wp_snap,
  input logic lock_snap,
  input logic page_msb
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_BUSY_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(end_ok)); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WRITE_CYCLES)); // R4
  AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ok && !buf_any_next) |=> !busy); // R5
  AST_LOWER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && lock_snap) |-> page_msb); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R7
  AST_WP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !wp_snap); // R8
  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_REG == 0 && busy) |-> !rd_valid); // R10
  AST_READ_BLOCKED_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_REG != 0 && $past(busy)) |-> !rd_valid); // R10

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES), .RD_REG(RD_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .lock_q(lock_q), .buf_any_next(buf_any_next), .end_ok(end_ok),
  .arr_we(arr_we), .wp_snap(wp_snap), .lock_snap(lock_snap),
  .page_msb(page_msb)
);

// File: tb/tb_pgwr_ctrl.sv
module tb_pgwr_ctrl;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       txn_start = 0, byte_valid = 0, txn_end = 0, lock_cmd = 0, wp_pin = 0;
  logic [7:0] txn_addr = 0, byte_data = 0, rd_addr = 0;
  logic       busy0, busy1, rv0, rv1;
  logic [7:0] rd0, rd1;

  int   checks = 0, fails = 0;
  logic [7:0] model [256];
  bit   lock_m;

  pgwr_ctrl #(.WRITE_CYCLES(W), .RD_REG(0)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .txn_end(txn_end),
    .lock_cmd(lock_cmd), .wp_pin(wp_pin), .busy(busy0),
    .rd_addr(rd_addr), .rd_data(rd0), .rd_valid(rv0));

  pgwr_ctrl #(.WRITE_CYCLES(W), .RD_REG(1)) dut_r (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .txn_end(txn_end),
    .lock_cmd(lock_cmd), .wp_pin(wp_pin), .busy(busy1),
    .rd_addr(rd_addr), .rd_data(rd1), .rd_valid(rv1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Protection rule restated: pin blocks all, lock blocks addresses below 80h.
  function automatic bit may_write(input bit wp, input bit lk, input logic [7:0] a);
    if (wp) return 0;
    if (lk && a < 8'h80) return 0;
    return 1;
  endfunction

  task automatic do_reset();
    rst_n = 0; txn_start = 0; byte_valid = 0; txn_end = 0; lock_cmd = 0; wp_pin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    lock_m = 0;
  endtask

  task automatic verify_page(input logic [3:0] pg, input string req);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      a = {pg, i[3:0]};
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(rv0 === 1'b1 && rd0 === model[a], req, rd0, model[a]);
      @(negedge clk);
      chk(rv1 === 1'b1 && rd1 === model[a], {req, " R10"}, rd1, model[a]);
    end
  endtask

  task automatic run_txn(input logic [7:0] start, input int n, input bit wp,
                         input bit lock_end, input bit last_with_end,
                         input bit poke, input string req);
    logic [7:0] d [32];
    logic [7:0] pg_dat [16];
    bit         pg_vld [16];
    int         cnt;
    for (int k = 0; k < n; k++) d[k] = 8'($urandom);
    for (int k = 0; k < 16; k++) pg_vld[k] = 0;
    @(negedge clk);
    txn_start = 1; txn_addr = start; wp_pin = wp;
    @(negedge clk);
    txn_start = 0;
    for (int k = 0; k < n; k++) begin
      if (!(last_with_end && k == n - 1)) begin
        byte_valid = 1; byte_data = d[k];
        @(negedge clk);
      end
    end
    byte_valid = 0;
    txn_end = 1; lock_cmd = lock_end;
    if (last_with_end && n > 0) begin
      byte_valid = 1; byte_data = d[n-1];
    end
    @(negedge clk);
    txn_end = 0; lock_cmd = 0; byte_valid = 0;
    // Expected commit: offsets wrap in the page, later bytes replace earlier.
    for (int k = 0; k < n; k++) begin
      int off;
      off = (int'(start[3:0]) + k) % 16;
      pg_dat[off] = d[k]; pg_vld[off] = 1;
    end
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      a = {start[7:4], 4'(k)};
      if (pg_vld[k] && may_write(wp, lock_m, a)) model[a] = pg_dat[k];
    end
    if (lock_end) lock_m = 1;
    chk(busy0 === (n > 0), {req, " R4 R5 busy"}, busy0, (n > 0));
    if (n > 0) begin
      #1;
      chk(rv0 === 1'b0 && rd0 === 8'h00, {req, " R10 blocked"}, rd0, 0);
      wp_pin = !wp;
      cnt = 1;
      for (int g = 0; g < W + 4; g++) begin
        if (poke && g == 1) begin
          txn_start = 1; txn_addr = ~start; byte_valid = 1; byte_data = 8'h5A;
          txn_end = 1; lock_cmd = 1;
        end
        @(negedge clk);
        txn_start = 0; byte_valid = 0; txn_end = 0; lock_cmd = 0;
        if (g == 0) chk(rv1 === 1'b0 && rd1 === 8'h00, {req, " R10 reg blocked"}, rd1, 0);
        if (busy0) cnt++;
        else break;
      end
      chk(cnt == W, {req, " R4 length"}, cnt, W);
      wp_pin = 0;
    end else begin
      @(negedge clk);
      chk(busy0 === 1'b0, {req, " R5 stays idle"}, busy0, 0);
    end
    verify_page(start[7:4], req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'h5EED);
    do_reset();
    @(negedge clk);
    chk(busy0 === 1'b0 && rv0 === 1'b1, "R1 idle after reset", busy0, 0);
    for (int p = 0; p < 16; p++) verify_page(4'(p), "R1 zero array");

    run_txn(8'h3E, 3, 0, 0, 0, 1, "R1 R2 R9 wrap");
    run_txn(8'h85, 20, 0, 0, 0, 0, "R3 overflow");
    run_txn(8'h40, 0, 0, 0, 0, 0, "R5 empty");
    run_txn(8'h12, 5, 1, 0, 0, 0, "R8 pin unlocked");
    for (int t = 0; t < 20; t++)
      run_txn(8'($urandom), $urandom_range(0, 20), ($urandom_range(0, 4) == 0), 0,
              $urandom_range(0, 1), $urandom_range(0, 1), "R2 R3 random open");

    run_txn(8'h20, 4, 0, 1, 1, 0, "R11 same cycle");
    run_txn(8'h22, 6, 0, 0, 0, 0, "R6 R11 lower blocked");
    run_txn(8'hC7, 6, 0, 0, 0, 0, "R6 upper open");
    run_txn(8'h05, 3, 0, 1, 0, 1, "R7 relock");
    run_txn(8'hF0, 16, 1, 0, 0, 0, "R8 pin upper");
    for (int t = 0; t < 20; t++)
      run_txn(8'($urandom), $urandom_range(0, 20), ($urandom_range(0, 4) == 0), 0,
              $urandom_range(0, 1), $urandom_range(0, 1), "R6 R7 R8 random locked");

    do_reset();
    run_txn(8'h00, 2, 0, 0, 0, 0, "R7 reset clears lock");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule